// File: doc/BRIEF.md
# Framebuffer CPU Write Port with Transparent Overwrite

This block sits between a processor bus and a two-bank video framebuffer. The processor writes bytes or 16-bit words and reads words back through one address window. The bit just above the bank offset splits the window into two aliases of the same storage. In the normal alias, a word write stores exactly what was sent. In the overwrite alias, zero bytes are treated as transparent pixels and leave the stored byte untouched. Byte writes with a zero value are discarded in both aliases, so the processor can draw sprites with a zero background over an existing image.

A word write to the overwrite alias is carried out as a read-modify-write over two cycles. `cpu_ready` drops for the second cycle. A one-bit bank select chooses which bank the processor sees. The byte offset width is a parameter: the default is small, and 17 gives full 128 KiB banks with the alias bit at address bit 17.

Top module: `fb_write_port`

## Requirements
- R1: A byte write with a nonzero data byte (`cpu_wdata[7:0]`) updates exactly one lane of the addressed word, and the lanes are big-endian. An even address (`cpu_addr[0]`=0) writes bits 15:8. An odd address writes bits 7:0.
- R2: A byte write whose data byte is zero changes nothing, in either alias.
- R3: A word write (`cpu_word`=1) to the normal alias (`cpu_addr[OFFS_W]`=0) stores all 16 bits, including any zero bytes. Word accesses ignore `cpu_addr[0]`.
- R4: A word write to the overwrite alias (`cpu_addr[OFFS_W]`=1) treats each byte separately. A zero high byte keeps the stored bits 15:8, a zero low byte keeps the stored bits 7:0, and a nonzero byte replaces the stored one.
- R5: A read accepted at a clock edge presents the addressed word on `cpu_rdata` after that edge. The same word is returned from both aliases. `cpu_rdata` holds its value in every cycle without an accepted read.
- R6: `bank_sel` picks the bank that accepted accesses use. The other bank is not altered.
- R7: After an overwrite-alias word write is accepted, `cpu_ready` is low for exactly one cycle. Byte writes, normal word writes and reads leave `cpu_ready` high.
- R8: Strobes presented while `cpu_ready` is low are ignored.
- R9: Changing `bank_sel` while an overwrite merge is pending does not redirect that merge. The merge completes in the bank that was selected when the write was accepted.
- R10: After reset, `cpu_ready` is high and `cpu_rdata` is zero. A strobe with `cpu_wr` high is a write. `cpu_rd` counts only when `cpu_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | Bank visible to the processor |
| cpu_addr | input | OFFS_W+1 | Byte address. The top bit selects the overwrite alias |
| cpu_wdata | input | 16 | Write data. Byte writes use bits 7:0 |
| cpu_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_ready | output | 1 | High when a new access can be accepted |
| cpu_rdata | output | 16 | Registered read data |

## Verification
Two events can fall in the same cycle: the write phase of a pending overwrite merge, and a new strobe or bank change from the processor. The bench provokes this by driving a second write, or flipping `bank_sel`, in the very cycle `cpu_ready` is low. It then reads both banks back. The check passes only if the merged word landed in the originally selected bank and the strobed address is unchanged. Random mixes of byte, normal-word and overwrite-word traffic with frequent zero bytes are compared against a bench model of both banks.

// File: rtl/fb_pkg.sv
package fb_pkg;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_BYTE,
        WK_WORD,
        WK_MERGE
    } wkind_e;

    typedef enum logic {
        SQ_IDLE,
        SQ_MERGE
    } seq_e;

    typedef struct packed {
        logic        hi;
        logic        lo;
        logic [15:0] data;
    } lane_wr_t;

    function automatic logic [7:0] keep_if_zero(input logic [7:0] nv, input logic [7:0] ov);
        return (nv == 8'h00) ? ov : nv;
    endfunction

endpackage

// File: rtl/fb_lane_filter.sv
module fb_lane_filter
    import fb_pkg::*;
(
    input  wkind_e      kind,
    input  logic        lane_hi,
    input  logic [15:0] wdata,
    input  logic [15:0] old_word,
    output lane_wr_t    lw
);
    logic nz;
    assign nz = (wdata[7:0] != 8'h00);

    always_comb begin
        lw = '0;
        unique case (kind)
            WK_BYTE: begin
                lw.hi   = nz & lane_hi;
                lw.lo   = nz & ~lane_hi;
                lw.data = {wdata[7:0], wdata[7:0]};
            end
            WK_WORD: begin
                lw.hi   = 1'b1;
                lw.lo   = 1'b1;
                lw.data = wdata;
            end
            WK_MERGE: begin
                lw.hi   = 1'b1;
                lw.lo   = 1'b1;
                lw.data = {keep_if_zero(wdata[15:8], old_word[15:8]),
                           keep_if_zero(wdata[7:0], old_word[7:0])};
            end
            default: lw = '0;
        endcase
    end
endmodule

// File: rtl/fb_bank_store.sv
module fb_bank_store
    import fb_pkg::*;
#(
    parameter int WADDR_W = 9,
    parameter int BANKS   = 2,
    localparam int DEPTH  = 1 << WADDR_W,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [BANK_W-1:0]  wr_bank,
    input  logic [WADDR_W-1:0] wr_addr,
    input  lane_wr_t           wr,
    input  logic [BANK_W-1:0]  rd_bank,
    input  logic [WADDR_W-1:0] rd_addr,
    output logic [15:0]        rd_word
);
    logic [15:0] bank_rd [BANKS];

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic [15:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && wr_bank == BANK_W'(g)) begin
                if (wr.hi) mem[wr_addr][15:8] <= wr.data[15:8];
                if (wr.lo) mem[wr_addr][7:0]  <= wr.data[7:0];
            end
        end
        assign bank_rd[g] = mem[rd_addr];
    end

    assign rd_word = bank_rd[rd_bank];
endmodule

// File: rtl/fb_write_seq.sv
module fb_write_seq
    import fb_pkg::*;
#(
    parameter int WADDR_W = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WADDR_W-1:0] in_addr,
    input  logic [15:0]        in_data,
    input  logic               in_bank,
    output logic               busy,
    output logic [WADDR_W-1:0] pend_addr,
    output logic [15:0]        pend_data,
    output logic               pend_bank
);
    seq_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            pend_addr <= '0;
            pend_data <= '0;
            pend_bank <= 1'b0;
        end else if (state == SQ_IDLE) begin
            if (start) begin
                state     <= SQ_MERGE;
                pend_addr <= in_addr;
                pend_data <= in_data;
                pend_bank <= in_bank;
            end
        end else begin
            state <= SQ_IDLE;
        end
    end

    assign busy = (state == SQ_MERGE);

    // R7
    busy_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy);
    // R7
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);
    // R9
    pend_bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> pend_bank == $past(in_bank));
endmodule

// File: rtl/fb_write_port.sv
module fb_write_port
    import fb_pkg::*;
#(
    parameter int OFFS_W = 10,
    localparam int WADDR_W = OFFS_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bank_sel,
    input  logic [OFFS_W:0]   cpu_addr,
    input  logic [15:0]       cpu_wdata,
    input  logic              cpu_word,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic              cpu_ready,
    output logic [15:0]       cpu_rdata
);
    logic               busy, pend_bank, ovw, acc_wr, acc_rd, start;
    logic [WADDR_W-1:0] cpu_waddr, pend_addr, st_addr;
    logic [15:0]        pend_data, st_wdata, old_word;
    logic               st_bank;
    wkind_e             kind;
    lane_wr_t           lw;

    assign ovw       = cpu_addr[OFFS_W];
    assign cpu_waddr = cpu_addr[OFFS_W-1:1];
    assign acc_wr    = cpu_wr & ~busy;
    assign acc_rd    = cpu_rd & ~cpu_wr & ~busy;
    assign start     = acc_wr & cpu_word & ovw;

    always_comb begin
        if (busy)                 kind = WK_MERGE;
        else if (!acc_wr)         kind = WK_NONE;
        else if (!cpu_word)       kind = WK_BYTE;
        else if (ovw)             kind = WK_NONE;
        else                      kind = WK_WORD;
    end

    assign st_addr  = busy ? pend_addr : cpu_waddr;
    assign st_bank  = busy ? pend_bank : bank_sel;
    assign st_wdata = busy ? pend_data : cpu_wdata;

    fb_write_seq #(.WADDR_W(WADDR_W)) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .in_addr(cpu_waddr), .in_data(cpu_wdata), .in_bank(bank_sel),
        .busy(busy), .pend_addr(pend_addr), .pend_data(pend_data),
        .pend_bank(pend_bank)
    );

    fb_lane_filter u_filt (
        .kind(kind), .lane_hi(~cpu_addr[0]), .wdata(st_wdata),
        .old_word(old_word), .lw(lw)
    );

    fb_bank_store #(.WADDR_W(WADDR_W), .BANKS(2)) u_store (
        .clk(clk), .wr_en(kind != WK_NONE), .wr_bank(st_bank),
        .wr_addr(st_addr), .wr(lw), .rd_bank(st_bank),
        .rd_addr(st_addr), .rd_word(old_word)
    );

    always_ff @(posedge clk) begin
        if (rst)         cpu_rdata <= '0;
        else if (acc_rd) cpu_rdata <= old_word;
    end

    assign cpu_ready = ~busy;

    // R2
    zero_byte_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && !cpu_word && cpu_wdata[7:0] == 8'h00) |-> !(lw.hi || lw.lo));
    // R3
    normal_word_full_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && cpu_word && !ovw) |-> (lw.hi && lw.lo && lw.data == cpu_wdata));
    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_rd |=> $stable(cpu_rdata));
    // R7
    fast_ops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && (cpu_wr || cpu_rd) && !start) |=> cpu_ready);
endmodule

// File: tb/fb_write_port_test.sv
module fb_write_port_test;
    localparam int OFFS_W = 10;
    localparam int WORDS  = 1 << (OFFS_W - 1);

    logic              clk = 0, rst = 1, bank_sel = 0;
    logic [OFFS_W:0]   cpu_addr = '0;
    logic [15:0]       cpu_wdata = '0;
    logic              cpu_word = 0, cpu_wr = 0, cpu_rd = 0;
    logic              cpu_ready;
    logic [15:0]       cpu_rdata;

    int checks = 0, fails = 0;
    logic [15:0] ref_mem [2][WORDS];

    always #10 clk = ~clk;

    fb_write_port #(.OFFS_W(OFFS_W)) uut (
        .clk(clk), .rst(rst), .bank_sel(bank_sel), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_word(cpu_word), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_word(input logic [15:0] old, input logic [OFFS_W:0] a,
                                               input logic [15:0] d, input logic word);
        logic [15:0] r = old;
        if (!word) begin
            if (d[7:0] != 0) begin
                if (!a[0]) r[15:8] = d[7:0];
                else       r[7:0]  = d[7:0];
            end
        end else if (!a[OFFS_W]) r = d;
        else begin
            if (d[15:8] != 0) r[15:8] = d[15:8];
            if (d[7:0]  != 0) r[7:0]  = d[7:0];
        end
        return r;
    endfunction

    // write issued at a negedge; returns at the negedge after acceptance
    task automatic wr_op(input logic b, input logic [OFFS_W:0] a, input logic [15:0] d,
                         input logic word, input bit chk_ready);
        logic [OFFS_W-1:1] w = a[OFFS_W-1:1];
        bank_sel = b; cpu_addr = a; cpu_wdata = d; cpu_word = word; cpu_wr = 1;
        @(negedge clk);
        cpu_wr = 0;
        ref_mem[b][w] = model_word(ref_mem[b][w], a, d, word);
        if (word && a[OFFS_W]) begin
            if (chk_ready) check("R7 ready low after overwrite word", {15'd0, cpu_ready}, 16'd0);
            @(negedge clk);
            if (chk_ready) check("R7 ready back after one cycle", {15'd0, cpu_ready}, 16'd1);
        end else if (chk_ready) check("R7 ready stays high", {15'd0, cpu_ready}, 16'd1);
    endtask

    task automatic rd_chk(input string tag, input logic b, input logic [OFFS_W:0] a);
        bank_sel = b; cpu_addr = a; cpu_rd = 1;
        @(negedge clk);
        cpu_rd = 0;
        check(tag, cpu_rdata, ref_mem[b][a[OFFS_W-1:1]]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [OFFS_W:0] a;
        logic [15:0] d, keep;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        check("R10 ready after reset", {15'd0, cpu_ready}, 16'd1);
        check("R10 rdata after reset", cpu_rdata, 16'd0);

        // fill both banks through the normal alias
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < WORDS; i++)
                wr_op(b[0], {1'b0, i[OFFS_W-2:0], 1'b0}, 16'($urandom), 1'b1, 1'b0);

        // R1 big-endian lanes
        wr_op(0, 11'h010, 16'h1234, 1, 0);
        wr_op(0, 11'h010, 16'h00AA, 0, 1);
        rd_chk("R1 even byte to high lane", 0, 11'h010);
        check("R1 even byte value", cpu_rdata, 16'hAA34);
        wr_op(0, 11'h011, 16'h0055, 0, 1);
        rd_chk("R1 odd byte to low lane", 0, 11'h010);
        check("R1 odd byte value", cpu_rdata, 16'hAA55);
        // R2 zero bytes dropped in both aliases
        wr_op(0, 11'h010, 16'hFF00, 0, 1);
        wr_op(0, 11'h411, 16'h7700, 0, 1);
        rd_chk("R2 zero byte dropped", 0, 11'h010);
        check("R2 zero byte value", cpu_rdata, 16'hAA55);
        // R3 normal word with zero bytes, addr bit0 ignored
        wr_op(0, 11'h021, 16'h0000, 1, 1);
        rd_chk("R3 normal word stores zeros", 0, 11'h020);
        check("R3 zero word value", cpu_rdata, 16'h0000);
        // R4 merge
        wr_op(0, 11'h030, 16'hABCD, 1, 1);
        wr_op(0, 11'h430, 16'h0012, 1, 1);
        rd_chk("R4 zero high byte kept", 0, 11'h030);
        check("R4 merge value", cpu_rdata, 16'hAB12);
        wr_op(0, 11'h430, 16'h0000, 1, 1);
        rd_chk("R4 all-zero overwrite keeps word", 0, 11'h030);
        wr_op(0, 11'h430, 16'h9900, 1, 1);
        rd_chk("R4 zero low byte kept", 0, 11'h030);
        check("R4 merge value 2", cpu_rdata, 16'h9912);
        // R5 alias read and hold
        rd_chk("R5 read via overwrite alias", 0, 11'h430);
        keep = cpu_rdata;
        @(negedge clk);
        check("R5 rdata held without read", cpu_rdata, keep);
        // R10 write wins over read
        cpu_rd = 1;
        wr_op(1, 11'h040, 16'h4321, 1, 0);
        cpu_rd = 0;
        check("R10 read ignored with write", cpu_rdata, keep);
        // R6 bank isolation
        wr_op(1, 11'h030, 16'h5A5A, 1, 1);
        rd_chk("R6 bank 1 written", 1, 11'h030);
        rd_chk("R6 bank 0 untouched", 0, 11'h030);
        // R8 strobe during busy ignored
        wr_op(0, 11'h050, 16'h1111, 1, 0);
        bank_sel = 0; cpu_addr = 11'h450; cpu_wdata = 16'h2200; cpu_word = 1; cpu_wr = 1;
        @(negedge clk);
        bank_sel = 0; cpu_addr = 11'h060; cpu_wdata = 16'hBEEF; cpu_word = 1;
        check("R8 ready low during merge", {15'd0, cpu_ready}, 16'd0);
        @(negedge clk);
        cpu_wr = 0;
        ref_mem[0][8'h28] = 16'h2211;
        rd_chk("R8 merge done", 0, 11'h050);
        rd_chk("R8 busy strobe ignored", 0, 11'h060);
        // R9 bank change during merge
        wr_op(0, 11'h070, 16'hABCD, 1, 0);
        wr_op(1, 11'h070, 16'h1111, 1, 0);
        bank_sel = 0; cpu_addr = 11'h470; cpu_wdata = 16'h0012; cpu_word = 1; cpu_wr = 1;
        @(negedge clk);
        cpu_wr = 0; bank_sel = 1;
        @(negedge clk);
        ref_mem[0][8'h38] = 16'hAB12;
        rd_chk("R9 merge stays in bank 0", 0, 11'h070);
        rd_chk("R9 bank 1 not hit", 1, 11'h070);

        // random mix
        for (int n = 0; n < 600; n++) begin
            a = OFFS_W'($urandom) | ((OFFS_W + 1)'($urandom_range(0, 1)) << OFFS_W);
            d = 16'($urandom);
            if ($urandom_range(0, 2) == 0) d[7:0] = 0;
            if ($urandom_range(0, 2) == 0) d[15:8] = 0;
            case ($urandom_range(0, 3))
                0: wr_op(1'($urandom), a, d, 0, 1);
                1, 2: wr_op(1'($urandom), a, d, 1, 1);
                default: rd_chk("R5 random readback", 1'($urandom), a);
            endcase
        end
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < WORDS; i += 7)
                rd_chk("R6 final bank sweep", b[0], {1'b1, i[OFFS_W-2:0], 1'b0});

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule